// File: doc/BRIEF.md
# Masked Write GPIO Register

A single memory-mapped control register drives four output lines. Two of them form a software-driven serial pair for an external real-time clock: a clock line and an open-drain data line. The other two are an active-low LED line and a power-hold line. Every write carries its own enable mask alongside the new line values. Only the lines whose mask bit is set in that same write take the new value, so software can toggle one line without first reading the others back.

A read returns a 16-bit board identifier taken from input pins, together with the current line states. On the data position it returns the synchronized level of the external data pin while the block has the line released. This lets software receive bits from the clock chip over the same register. The serial protocol is run entirely by software; the block only holds levels.

Top module: `masked_gpio_reg`

## Requirements
- R1: While reset is asserted and after it is released, with no write yet, `pwr_hold_o` is 1, `led_o` is 1 (LED off), `rtc_sck_o` is 1, and the data line is released (`rtc_dat_oe_o` is 0).
- R2: A write with bit 6 set loads `rtc_sck_o` from write bit 2. A write with bit 7 set loads the data state from write bit 3: a 0 drives the line low and a 1 releases it. The change is visible after the clock edge that samples the write.
- R3: A write with bit 5 set loads `led_o` from write bit 1. A 0 lights the LED and a 1 turns it off.
- R4: A write with bit 4 set loads `pwr_hold_o` from write bit 0. A 1 keeps the system on and a 0 requests power-off.
- R5: A line whose mask bit is clear in a write keeps its value. Write bits 31:8 have no effect on any line.
- R6: Read bits 31:16 always equal `board_id_i`.
- R7: Read bit 2 is the clock line, bit 1 the LED line and bit 0 the power line. Read bits 15:4 are always zero.
- R8: Read bit 3 is 0 while the block drives the data line low. While the line is released, bit 3 is `rtc_dat_i` passed through a synchronizer of `SYNC_STAGES` flops, so a change on the pin shows after that many clock edges.
- R9: `rtc_dat_oe_o` is 1 exactly when the stored data state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data: masks in 7:4, values in 3:0 |
| rd_data_o | output | 32 | Read data: identifier, zeros, line states |
| board_id_i | input | 16 | Board identifier pins |
| rtc_dat_i | input | 1 | Level of the external serial data pin |
| rtc_sck_o | output | 1 | Serial clock line |
| rtc_dat_oe_o | output | 1 | Pull the serial data line low when 1 |
| led_o | output | 1 | LED line, active low |
| pwr_hold_o | output | 1 | Power-hold line |

## Verification
Two functions can meet in the same cycle. One is a write that releases the data line. The other is a change of the external data pin, which feeds the read-back path. The bench drives both on the same falling edge. It then judges the read-back bit edge by edge: the bit must stay at 0 while the line is still driven, and must show the new pin level only once the synchronizer delay has passed. The masked-write table also puts set and clear masks for different lines into one write, to show that each group decides on its own mask.

// File: rtl/masked_gpio_pkg.sv
package masked_gpio_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ID_W    = 16;
  localparam int unsigned NLINES  = 4;
  // value bit positions; mask of line k sits at k + NLINES
  localparam int unsigned PWR_B   = 0;
  localparam int unsigned LED_B   = 1;
  localparam int unsigned SCK_B   = 2;
  localparam int unsigned DAT_B   = 3;
  localparam logic [NLINES-1:0] LINE_RST = 4'b1111;

  typedef struct packed {
    logic dat;
    logic sck;
    logic led;
    logic pwr;
  } line_state_t;
endpackage

// File: rtl/masked_gpio_field.sv
module masked_gpio_field #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[b] <= RST_VAL[b];
      else if (we_i && mask_i[b]) q_o[b] <= val_i[b];
    end
  end
endmodule

// File: rtl/masked_gpio_sync.sv
module masked_gpio_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/masked_gpio_reg.sv
module masked_gpio_reg
  import masked_gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ID_W-1:0]   board_id_i,
  input  logic              rtc_dat_i,
  output logic              rtc_sck_o,
  output logic              rtc_dat_oe_o,
  output logic              led_o,
  output logic              pwr_hold_o
);
  localparam int unsigned RSV_W = DATA_W - ID_W - NLINES;

  line_state_t      line_q;
  logic [NLINES-1:0] line_bits;
  logic             dat_sync;
  logic             dat_rd;

  masked_gpio_field #(
    .W       (NLINES),
    .RST_VAL (LINE_RST)
  ) u_field (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i),
    .mask_i (wr_data_i[2*NLINES-1:NLINES]),
    .val_i  (wr_data_i[NLINES-1:0]),
    .q_o    (line_bits)
  );

  assign line_q = line_state_t'(line_bits);

  masked_gpio_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rtc_dat_i),
    .q_o    (dat_sync)
  );

  // released line reads the pin, driven line reads low
  assign dat_rd = line_q.dat ? dat_sync : 1'b0;

  assign rtc_sck_o    = line_q.sck;
  assign rtc_dat_oe_o = ~line_q.dat;
  assign led_o        = line_q.led;
  assign pwr_hold_o   = line_q.pwr;

  assign rd_data_o = {board_id_i, {RSV_W{1'b0}}, dat_rd, line_q.sck, line_q.led, line_q.pwr};
endmodule

// File: rtl/masked_gpio_chk.sv
module masked_gpio_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic [15:0] board_id_i,
  input logic        rtc_dat_i,
  input logic        rtc_sck_o,
  input logic        rtc_dat_oe_o,
  input logic        led_o,
  input logic        pwr_hold_o
);
  // R2
  sck_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[6] |=> rtc_sck_o == $past(wr_data_i[2]));
  // R9
  dat_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[7] |=> rtc_dat_oe_o == !$past(wr_data_i[3]));
  // R3
  led_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[5] |=> led_o == $past(wr_data_i[1]));
  // R4
  pwr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[4] |=> pwr_hold_o == $past(wr_data_i[0]));
  // R5
  pwr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[4]) |=> $stable(pwr_hold_o));
  // R5
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[5]) |=> $stable(led_o));
  // R5
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[6]) |=> $stable(rtc_sck_o));
  // R6
  board_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:16] == board_id_i);
  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15:4] == 12'h000);
  // R8
  driven_low_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_dat_oe_o |-> !rd_data_o[3]);
endmodule

bind masked_gpio_reg masked_gpio_chk u_chk (.*);

// File: tb/masked_gpio_reg_tb.sv
module masked_gpio_reg_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;

  typedef struct packed {
    logic [31:0] wr;
    logic [3:0]  exp;  // {dat, sck, led, pwr} as read with pin high
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 4'b1111},  // R5 no mask
    '{32'h0000_0010, 4'b1110},  // R4 power off
    '{32'h0000_0021, 4'b1100},  // R3 led on, R5 pwr value ignored
    '{32'h0000_0040, 4'b1000},  // R2 clock low
    '{32'h0000_0080, 4'b0000},  // R2 data driven low
    '{32'h0000_00FF, 4'b1111},  // all lines high
    '{32'h0000_0070, 4'b1000},  // clock, led, power low
    '{32'h0000_00C4, 4'b0100},  // data low, clock high
    '{32'hFFFF_FF0F, 4'b0100},  // R5 upper bits ignored
    '{32'h0000_003A, 4'b0110}   // led off, power off
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [15:0] board_id_i = 16'hA5C3;
  logic        rtc_dat_i = 1'b1;
  logic        rtc_sck_o, rtc_dat_oe_o, led_o, pwr_hold_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  masked_gpio_reg dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1ns);
    // R1 during reset
    check("R1 reset lines", {rtc_dat_oe_o, rtc_sck_o, led_o, pwr_hold_o}, 4'b0111);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 after release
    check("R1 after release", {rtc_dat_oe_o, rtc_sck_o, led_o, pwr_hold_o}, 4'b0111);
    check("R1 read state", rd_data_o[3:0], 4'hF);

    for (int i = 0; i < NVEC; i++) begin
      write_reg(VECS[i].wr);
      check($sformatf("R2/R3/R4/R5 vec %0d read", i), rd_data_o[3:0], VECS[i].exp);
      check($sformatf("R2/R3/R4/R9 vec %0d pins", i),
            {~rtc_dat_oe_o, rtc_sck_o, led_o, pwr_hold_o}, VECS[i].exp);
    end

    // R6 identifier follows pins, R7 reserved zero
    check("R6 board id", rd_data_o[31:16], 16'hA5C3);
    board_id_i = 16'h5A3C;
    #1ns;
    check("R6 board id new", rd_data_o[31:16], 16'h5A3C);
    check("R7 reserved zero", rd_data_o[15:4], 12'h000);

    // R8: data driven low, pin high -> reads 0
    write_reg(32'h0000_0080);
    check("R8 driven low reads 0", rd_data_o[3], 1'b0);
    check("R9 oe when driven", rtc_dat_oe_o, 1'b1);

    // concurrent: release and pin falls in the same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = 32'h0000_0088;
    rtc_dat_i = 1'b0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
    check("R8 one edge old pin", rd_data_o[3], 1'b1);
    check("R9 released", rtc_dat_oe_o, 1'b0);
    @(negedge clk_i);
    check("R8 synced low", rd_data_o[3], 1'b0);
    rtc_dat_i = 1'b1;
    @(negedge clk_i);
    check("R8 rise one edge", rd_data_o[3], 1'b0);
    @(negedge clk_i);
    check("R8 synced high", rd_data_o[3], 1'b1);

    // R5 write with no masks leaves every line alone
    write_reg(32'h0000_000F);
    check("R5 no-mask write", {~rtc_dat_oe_o, rtc_sck_o, led_o, pwr_hold_o}, 4'b1110);

    // R1 reset again restores defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1ns;
    check("R1 re-reset", {rtc_dat_oe_o, rtc_sck_o, led_o, pwr_hold_o}, 4'b0111);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule